// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block turns a 32.768 kHz tick-enable pulse into a programmable periodic event. A 15-stage binary chain counts the ticks. A 4-bit rate code selects how many of the low stages must wrap before an event fires. Each event sets a sticky periodic flag and, when enabled, toggles a square-wave output. Software clears the flag by reading the flag register, which is seen here as a one-cycle read strobe.

A 3-bit chain-select field sets the chain mode. In normal mode the chain counts one per tick. In hold mode the chain is cleared and kept at zero. In the three bypass modes the front stages are skipped, which shortens long periods during test. The control byte packs the rate code, the chain select and a read-only update-in-progress bit. That bit is high for a short window before each wrap of the full chain, which is the one-second rollover in normal mode.

Top module: `rtc_pi_gen`

## Requirements
- R1: After reset, `ctrl_rdata_o` reads 0x60 (rate 0, chain select 110), and `pf_o` and `sqw_o` are 0.
- R2: A control write stores `ctrl_wdata_i[3:0]` as the rate code and `ctrl_wdata_i[6:4]` as the chain select. Bit 7 of the written byte is ignored. `ctrl_rdata_o` returns {uip, chain select, rate code}, with uip in bit 7.
- R3: In normal mode (chain select 010), a rate code n from 3 to 15 sets `pf_o` once every 2^(n-1) ticks.
- R4: Rate code 1 gives an event every 128 ticks, and rate code 2 gives one every 256 ticks.
- R5: Rate code 0 never produces an event, so `pf_o` stays 0.
- R6: Chain selects 110 and 111 hold the chain at zero, and so do the unused codes 000 and 001. While held there are no events and uip is 0. After release, the first event comes exactly one event interval later, counted from zero.
- R7: Chain selects 011, 100 and 101 advance the chain by 2^5, 2^10 and 2^15 per tick. With rate 15 this gives first events after 512, 16 and 1 ticks.
- R8: `pf_o` stays set until a `flag_rd_i` cycle clears it. If an event falls in the same cycle as the read, the flag stays set.
- R9: While `sqw_en_i` is 1, `sqw_o` toggles on every event. While `sqw_en_i` is 0, `sqw_o` is 0.
- R10: uip is 1 exactly while the chain count lies within the last 8 values before it wraps. In normal mode this is ticks 32760 to 32767 after release.
- R11: Only cycles with `tick_i` high advance the chain. Cycles without a tick change neither the count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz time-base enable, one cycle per tick |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_rdata_o | output | 8 | Control byte read value: {uip, select, rate} |
| flag_rd_i | input | 1 | Flag-register read strobe, clears the flag |
| sqw_en_i | input | 1 | Square-wave enable |
| pf_o | output | 1 | Sticky periodic flag |
| sqw_o | output | 1 | Square-wave output |

## Verification
The assertions assume that `tick_i`, `flag_rd_i` and `sqw_en_i` are synchronous, single-cycle qualified inputs, stable around the clock edge. They also assume the square-wave enable does not change in the same cycle as an event the check depends on. The stimulus drives every input only on the falling edge. It changes `sqw_en_i` and the chain mode only while the chain is held, so no event can coincide with a mode change. Read strobes are placed either well clear of events or, on purpose, on an event cycle, to exercise the rule that a set wins over a clear.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;
  localparam int RATE_W = 4;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_NORMAL = 3'b010;
  localparam logic [SEL_W-1:0] SEL_BYP_A  = 3'b011;
  localparam logic [SEL_W-1:0] SEL_BYP_B  = 3'b100;
  localparam logic [SEL_W-1:0] SEL_BYP_C  = 3'b101;

  // aliased low codes reuse slower periods
  localparam int ALIAS1_SHIFT = 7;
  localparam int ALIAS2_SHIFT = 8;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [RATE_W-1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/rtc_pi_rate_dec.sv
module rtc_pi_rate_dec
  import rtc_pi_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int SH_W    = $clog2(CHAIN_W + 1)
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              en_o,
  output logic [SH_W-1:0]   shift_o
);
  localparam logic [SH_W-1:0] SH_MAX = SH_W'(CHAIN_W - 1);

  logic [SH_W-1:0] raw;

  always_comb begin
    en_o = 1'b1;
    raw  = SH_W'(rate_i) - SH_W'(1);
    unique case (rate_i)
      4'd0: begin en_o = 1'b0; raw = '0; end
      4'd1: raw = SH_W'(ALIAS1_SHIFT);
      4'd2: raw = SH_W'(ALIAS2_SHIFT);
      default: ;
    endcase
    shift_o = (raw > SH_MAX) ? SH_MAX : raw;
  end
endmodule

// File: rtl/rtc_pi_sel_dec.sv
module rtc_pi_sel_dec
  import rtc_pi_pkg::*;
#(
  parameter int CHAIN_W  = 15,
  parameter int BYP_STEP = 5,
  parameter int SH_W     = $clog2(CHAIN_W + 1)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             run_o,
  output logic [SH_W-1:0]  byp_o
);
  localparam logic [SH_W-1:0] BYP1 = SH_W'(BYP_STEP);
  localparam logic [SH_W-1:0] BYP2 = SH_W'(2 * BYP_STEP);
  localparam logic [SH_W-1:0] BYP3 = SH_W'(3 * BYP_STEP);

  always_comb begin
    run_o = 1'b1;
    byp_o = '0;
    unique case (sel_i)
      SEL_NORMAL: byp_o = '0;
      SEL_BYP_A:  byp_o = BYP1;
      SEL_BYP_B:  byp_o = BYP2;
      SEL_BYP_C:  byp_o = BYP3;
      default:    run_o = 1'b0;  // 110, 111 and unused codes hold
    endcase
  end
endmodule

// File: rtl/rtc_pi_chain.sv
module rtc_pi_chain #(
  parameter int CHAIN_W = 15,
  parameter int UIP_WIN = 8,
  parameter int SH_W    = $clog2(CHAIN_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic [SH_W-1:0] byp_i,
  input  logic            rate_en_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            evt_o,
  output logic            uip_o
);
  localparam logic [CHAIN_W-1:0] UIP_START = CHAIN_W'((1 << CHAIN_W) - UIP_WIN);

  logic [CHAIN_W-1:0] cnt_q, cnt_nxt, mask;
  logic [CHAIN_W:0]   inc;

  always_comb begin
    inc     = {{CHAIN_W{1'b0}}, 1'b1} << byp_i;
    cnt_nxt = cnt_q + inc[CHAIN_W-1:0];
  end

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_mask
    assign mask[i] = (SH_W'(i) < shift_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  assign evt_o = tick_i && run_i && rate_en_i && ((cnt_nxt & mask) == '0);
  assign uip_o = run_i && (cnt_q >= UIP_START);

  assert_hold_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !uip_o);
  assert_no_tick_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q) || !run_i);
endmodule

// File: rtl/rtc_pi_flag.sv
module rtc_pi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_i,
  input  logic sqw_en_i,
  output logic pf_o,
  output logic sqw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pf_o <= 1'b0;
    else if (evt_i) pf_o <= 1'b1;  // set beats clear
    else if (rd_i)  pf_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sqw_o <= 1'b0;
    else if (!sqw_en_i) sqw_o <= 1'b0;
    else if (evt_i)     sqw_o <= ~sqw_o;
  end

  assert_pf_needs_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_o) |-> $past(evt_i));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !evt_i) |=> !pf_o);
  assert_sqw_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqw_en_i |=> !sqw_o);
  assert_sqw_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sqw_en_i && $past(sqw_en_i) && !$stable(sqw_o)) |-> $past(evt_i));
endmodule

// File: rtl/rtc_pi_gen.sv
module rtc_pi_gen
  import rtc_pi_pkg::*;
#(
  parameter int CHAIN_W  = 15,
  parameter int UIP_WIN  = 8,
  parameter int BYP_STEP = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_rdata_o,
  input  logic       flag_rd_i,
  input  logic       sqw_en_i,
  output logic       pf_o,
  output logic       sqw_o
);
  localparam int    SH_W       = $clog2(CHAIN_W + 1);
  localparam ctrl_t CTRL_RESET = '{sel: 3'b110, rate: '0};

  ctrl_t           ctrl_q;
  logic            run, rate_en, evt, uip;
  logic [SH_W-1:0] byp, shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RESET;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i[SEL_W+RATE_W-1:0]);
  end

  rtc_pi_rate_dec #(.CHAIN_W(CHAIN_W), .SH_W(SH_W)) u_rate (
    .rate_i (ctrl_q.rate),
    .en_o   (rate_en),
    .shift_o(shift)
  );

  rtc_pi_sel_dec #(.CHAIN_W(CHAIN_W), .BYP_STEP(BYP_STEP), .SH_W(SH_W)) u_sel (
    .sel_i(ctrl_q.sel),
    .run_o(run),
    .byp_o(byp)
  );

  rtc_pi_chain #(.CHAIN_W(CHAIN_W), .UIP_WIN(UIP_WIN), .SH_W(SH_W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .byp_i    (byp),
    .rate_en_i(rate_en),
    .shift_i  (shift),
    .evt_o    (evt),
    .uip_o    (uip)
  );

  rtc_pi_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .rd_i    (flag_rd_i),
    .sqw_en_i(sqw_en_i),
    .pf_o    (pf_o),
    .sqw_o   (sqw_o)
  );

  assign ctrl_rdata_o = {uip, ctrl_q.sel, ctrl_q.rate};

  assert_rate_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.rate == '0) |-> !evt);
  assert_hold_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.sel[2:1] == 2'b11 || ctrl_q.sel[2:1] == 2'b00) |-> (!evt && !ctrl_rdata_o[7]));
  assert_no_tick_no_evt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !evt);
endmodule

// File: tb/rtc_pi_gen_test.sv
`timescale 1ns/1ps
module rtc_pi_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [7:0] ctrl_rdata_o;
  logic       flag_rd_i = 1'b0;
  logic       sqw_en_i = 1'b0;
  logic       pf_o, sqw_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_mode = 0;  // 0 always, 1 every other cycle, 2 off

  always #2 clk = ~clk;

  rtc_pi_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .flag_rd_i(flag_rd_i), .sqw_en_i(sqw_en_i), .pf_o(pf_o), .sqw_o(sqw_o)
  );

  always @(negedge clk) begin
    if (tick_mode == 0)      tick_i = 1'b1;
    else if (tick_mode == 1) tick_i = ~tick_i;
    else                     tick_i = 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctrl_we_i = 1'b1;
    ctrl_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    ctrl_we_i = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk);
    flag_rd_i = 1'b1;
    @(negedge clk);
    flag_rd_i = 1'b0;
  endtask

  // counts ticks until pf_o is seen high; starts and ends on a falling edge
  task automatic meas(input bit rd_first, output int n);
    n = 0;
    flag_rd_i = rd_first;
    for (int i = 0; i < 40000; i++) begin
      @(posedge clk);
      if (tick_i) n++;
      @(negedge clk);
      flag_rd_i = 1'b0;
      if (pf_o) break;
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pf_o || ctrl_rdata_o[7]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    int n, m, p, bad;
    int codes[15] = '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 1, 2};

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata_o == 8'h60, "R1 rdata", ctrl_rdata_o, 8'h60);
    chk(pf_o == 1'b0, "R1 pf", pf_o, 0);
    chk(sqw_o == 1'b0, "R1 sqw", sqw_o, 0);

    // R2 layout, bit 7 write ignored
    wr(8'hF6);
    chk(ctrl_rdata_o == 8'h76, "R2 rdata", ctrl_rdata_o, 8'h76);

    // R3 R4 R9 rate sweep in normal mode
    foreach (codes[k]) begin
      p = (codes[k] == 1) ? 128 : (codes[k] == 2) ? 256 : (1 << (codes[k] - 1));
      wr(8'h60 | 8'(codes[k]));
      @(negedge clk);
      sqw_en_i = 1'b0;
      flag_rd_i = 1'b1;
      @(negedge clk);
      sqw_en_i = 1'b1;
      flag_rd_i = 1'b0;
      wr(8'h20 | 8'(codes[k]));
      meas(1'b0, n);
      chk(n == p, (codes[k] < 3) ? "R4 first interval" : "R3 first interval", n, p);
      chk(sqw_o == 1'b1, "R9 sqw after first event", sqw_o, 1);
      meas(1'b1, n);
      chk(n == p, (codes[k] < 3) ? "R4 second interval" : "R3 second interval", n, p);
      chk(sqw_o == 1'b0, "R9 sqw after second event", sqw_o, 0);
    end

    // R5 rate 0 never fires; R10 uip window
    wr(8'h60);
    clr();
    wr(8'h20);
    chk(ctrl_rdata_o == 8'h20, "R2 readback", ctrl_rdata_o, 8'h20);
    n = 0;
    bad = 0;
    for (int i = 0; i < 40000; i++) begin
      @(posedge clk);
      if (tick_i) n++;
      @(negedge clk);
      if (pf_o) bad++;
      if (ctrl_rdata_o[7]) break;
    end
    chk(n == 32760, "R10 uip rise", n, 32760);
    m = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      if (tick_i) m++;
      @(negedge clk);
      if (pf_o) bad++;
      if (!ctrl_rdata_o[7]) break;
    end
    chk(m == 8, "R10 uip width", m, 8);
    chk(bad == 0, "R5 rate 0 no flag", bad, 0);

    // R6 hold codes
    wr(8'h63); clr(); quiet(100, "R6 hold 110");
    wr(8'h73); quiet(60, "R6 hold 111");
    wr(8'h03); quiet(60, "R6 hold 000");
    wr(8'h13); quiet(60, "R6 hold 001");
    wr(8'h23);
    meas(1'b0, n);
    chk(n == 4, "R6 release from zero", n, 4);
    wr(8'h63); clr();
    wr(8'h23);
    wr(8'h63);
    chk(pf_o == 1'b0, "R6 no event before re-hold", pf_o, 0);
    wr(8'h23);
    meas(1'b0, n);
    chk(n == 4, "R6 restart after re-hold", n, 4);

    // R7 bypass modes with rate 15
    wr(8'h6F); clr(); wr(8'h3F);
    meas(1'b0, n);
    chk(n == 512, "R7 bypass 5", n, 512);
    wr(8'h6F); clr(); wr(8'h4F);
    meas(1'b0, n);
    chk(n == 16, "R7 bypass 10", n, 16);
    wr(8'h6F); clr(); wr(8'h5F);
    meas(1'b0, n);
    chk(n == 1, "R7 bypass 15", n, 1);
    meas(1'b1, n);
    chk(n == 1, "R8 set wins over read", n, 1);

    // R8 sticky flag and clear without ticks
    wr(8'h63); clr(); wr(8'h23);
    meas(1'b0, n);
    chk(n == 4, "R3 rate 3", n, 4);
    tick_mode = 2;
    repeat (10) @(negedge clk);
    chk(pf_o == 1'b1, "R8 sticky", pf_o, 1);
    clr();
    chk(pf_o == 1'b0, "R8 read clears", pf_o, 0);
    repeat (10) @(negedge clk);
    chk(pf_o == 1'b0, "R11 no tick no event", pf_o, 0);

    // R11 sparse ticks
    tick_mode = 1;
    wr(8'h64); clr(); wr(8'h24);
    meas(1'b0, n);
    chk(n == 8, "R11 sparse first", n, 8);
    meas(1'b1, n);
    chk(n == 8, "R11 sparse second", n, 8);

    // R9 disabled square wave
    tick_mode = 0;
    sqw_en_i = 1'b0;
    wr(8'h63); clr(); wr(8'h23);
    meas(1'b0, n);
    chk(sqw_o == 1'b0, "R9 disabled first", sqw_o, 0);
    meas(1'b1, n);
    chk(sqw_o == 1'b0, "R9 disabled second", sqw_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule